// File: doc/BRIEF.md
# Partitioned Byte-Lane Equality Comparator

This block compares two 64-bit operands for equality while treating the word as a set of independent lanes. The split is chosen at run time. A 7-bit boundary vector decides which byte edges separate one partition from the next, so a partition can start at any byte offset and cover from one to eight bytes. The block checks each partition as a whole. It then writes that partition's verdict to every byte-lane bit the partition owns. The result is one bit per byte of the word.

The block is purely combinational. A SIMD datapath uses it to get packed compare masks for 8-, 16-, 32- and 64-bit elements, and for irregular mixes of them, from one piece of hardware. Inside the block, a control part decodes the boundary bits into first-lane and last-lane strobes. A datapath part forms the per-byte equality terms, merges them across each partition and spreads the merged result over the partition's lanes.

Top module: `part_eq_cmp`

## Requirements
- R1: Byte lane k is bits 8k+7 down to 8k of each operand, and result bit k belongs to lane k. Boundary bit i (0..6), when 1, separates lane i from lane i+1.
- R2: Take any partition that starts at lane k and spans w lanes. Each of its result bits is 1 exactly when opA and opB match over bits 8k through 8(k+w)-1.
- R3: Every result bit inside one partition carries the same value. With boundary bit i at 0, result bits i and i+1 are equal.
- R4: With all boundary bits at 0, the block is a single 64-bit compare. All 8 result bits equal (opA == opB).
- R5: With all boundary bits at 1, result bit k reports only whether byte k of the two operands matches.
- R6: A byte difference outside a partition has no effect on that partition's result bits, for any partition offset and width.
- R7: The result follows the inputs combinationally, within the same cycle, with no clock or reset.
- R8: When opA equals opB, all result bits are 1 for every boundary pattern.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| gates | input | 7 | Partition boundary bits; bit i splits lane i from lane i+1 |
| laneEq | output | 8 | Per-lane equality result, replicated across each partition |

## Verification
The bench builds the block with its default shape: eight lanes of eight bits and seven boundary bits. At that size the whole boundary space of 128 patterns is small enough to walk completely. Every partition offset and every width from one to eight lanes is therefore exercised against a scanning reference model. In each pattern, single-byte differences are placed in random lanes. This shows both that a partition sees a mismatch inside it and that it ignores one outside it.

// File: rtl/part_eq_pkg.sv
package part_eq_pkg;
  parameter int unsigned PE_LANES  = 8;
  parameter int unsigned PE_LANE_W = 8;
  localparam int unsigned PE_WIDTH = PE_LANES * PE_LANE_W;
  localparam int unsigned PE_GATES = PE_LANES - 1;

  // Strobes from gate decode to the datapath
  typedef struct packed {
    logic [PE_LANES-1:0] laneFirst; // lane opens a partition
    logic [PE_LANES-1:0] laneLast;  // lane closes a partition
  } laneStrobes_t;
endpackage

// File: rtl/part_eq_ctrl.sv
module part_eq_ctrl
  import part_eq_pkg::*;
(
  input  logic [PE_GATES-1:0] gates,
  output laneStrobes_t        strobes
);
  genvar k;
  generate
    for (k = 0; k < PE_LANES; k++) begin : g_lane
      if (k == 0) begin : g_lo
        assign strobes.laneFirst[k] = 1'b1;
      end else begin : g_mid_lo
        assign strobes.laneFirst[k] = gates[k-1];
      end
      if (k == PE_LANES-1) begin : g_hi
        assign strobes.laneLast[k] = 1'b1;
      end else begin : g_mid_hi
        assign strobes.laneLast[k] = gates[k];
      end
    end
  endgenerate
endmodule

// File: rtl/part_eq_dp.sv
module part_eq_dp
  import part_eq_pkg::*;
(
  input  logic [PE_WIDTH-1:0] opA,
  input  logic [PE_WIDTH-1:0] opB,
  input  laneStrobes_t        strobes,
  output logic [PE_LANES-1:0] laneEq
);
  logic [PE_LANES-1:0] byteEq;
  logic [PE_LANES-1:0] tailEq;

  genvar k;
  generate
    for (k = 0; k < PE_LANES; k++) begin : g_byte
      assign byteEq[k] = (opA[k*PE_LANE_W +: PE_LANE_W] == opB[k*PE_LANE_W +: PE_LANE_W]);
    end
  endgenerate

  // Merge downward: tailEq[k] = equality from lane k up to its partition end
  always_comb begin
    tailEq = '0;
    for (int i = PE_LANES-1; i >= 0; i--) begin
      if (strobes.laneLast[i] || i == PE_LANES-1)
        tailEq[i] = byteEq[i];
      else
        tailEq[i] = byteEq[i] & tailEq[i+1];
    end
  end

  // Spread upward: the first lane carries the whole partition result
  always_comb begin
    laneEq = '0;
    for (int i = 0; i < PE_LANES; i++) begin
      if (strobes.laneFirst[i] || i == 0)
        laneEq[i] = tailEq[i];
      else
        laneEq[i] = laneEq[i-1];
    end
  end
endmodule

// File: rtl/part_eq_cmp.sv
module part_eq_cmp
  import part_eq_pkg::*;
(
  input  logic [PE_WIDTH-1:0] opA,
  input  logic [PE_WIDTH-1:0] opB,
  input  logic [PE_GATES-1:0] gates,
  output logic [PE_LANES-1:0] laneEq
);
  laneStrobes_t strobes;

  part_eq_ctrl u_ctrl (
    .gates   (gates),
    .strobes (strobes)
  );

  part_eq_dp u_dp (
    .opA     (opA),
    .opB     (opB),
    .strobes (strobes),
    .laneEq  (laneEq)
  );
endmodule

// File: rtl/part_eq_cmp_chk.sv
module part_eq_cmp_chk
  import part_eq_pkg::*;
(
  input logic [PE_WIDTH-1:0] opA,
  input logic [PE_WIDTH-1:0] opB,
  input logic [PE_GATES-1:0] gates,
  input logic [PE_LANES-1:0] laneEq
);
  always_comb begin
    if (gates == '0)
      p_whole_word_r4: assert (laneEq == {PE_LANES{opA == opB}});
    if (opA == opB)
      p_all_match_r8: assert (laneEq == {PE_LANES{1'b1}});
  end

  genvar k;
  generate
    for (k = 0; k < PE_LANES; k++) begin : g_chk
      always_comb begin
        if (gates == {PE_GATES{1'b1}})
          p_per_byte_r5: assert (laneEq[k] ==
            (opA[k*PE_LANE_W +: PE_LANE_W] == opB[k*PE_LANE_W +: PE_LANE_W]));
        if (laneEq[k])
          p_lane_implies_byte_r2: assert (opA[k*PE_LANE_W +: PE_LANE_W] ==
                                          opB[k*PE_LANE_W +: PE_LANE_W]);
      end
      if (k < PE_LANES-1) begin : g_join
        always_comb begin
          if (!gates[k])
            p_uniform_r3: assert (laneEq[k] == laneEq[k+1]);
        end
      end
    end
  endgenerate
endmodule

bind part_eq_cmp part_eq_cmp_chk u_chk (
  .opA    (opA),
  .opB    (opB),
  .gates  (gates),
  .laneEq (laneEq)
);

// File: tb/part_eq_cmp_tb.sv
module part_eq_cmp_tb;
  logic clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  logic [63:0] opA, opB;
  logic [6:0]  gates;
  logic [7:0]  laneEq;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  part_eq_cmp u_dut (.opA(opA), .opB(opB), .gates(gates), .laneEq(laneEq));

  typedef struct packed {
    logic [6:0]  g;
    logic [63:0] a;
    logic [63:0] b;
    logic [7:0]  exp;
  } vec_t;

  localparam int NVEC = 9;
  localparam vec_t VECS [NVEC] = '{
    '{7'h00, 64'h0123456789ABCDEF, 64'h0123456789ABCDEF, 8'hFF}, // R4 R8
    '{7'h00, 64'h0123456789ABCDEF, 64'h0123456700ABCDEF, 8'h00}, // R4
    '{7'h7F, 64'h1122334455667788, 64'h1122004455660088, 8'hDD}, // R5
    '{7'h08, 64'h0,                64'h0000000100000000, 8'h0F}, // R2
    '{7'h08, 64'h0,                64'h0000000000000100, 8'hF0}, // R2
    '{7'h41, 64'h0,                64'hFF00000000000000, 8'h7F}, // R6
    '{7'h41, 64'h0,                64'h00000000000000FF, 8'hFE}, // R6
    '{7'h41, 64'h0,                64'h0000010000000000, 8'h81}, // R6
    '{7'h24, 64'h0,                64'h0000000080000000, 8'hC7}  // R3
  };

  function automatic logic [7:0] refEq(logic [6:0] g, logic [63:0] a, logic [63:0] b);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < 8; k++) begin
      int lo, hi;
      logic same;
      lo = k;
      while (lo > 0 && !g[lo-1]) lo--;
      hi = k;
      while (hi < 7 && !g[hi]) hi++;
      same = 1'b1;
      for (int j = lo*8; j < hi*8+8; j++)
        if (a[j] !== b[j]) same = 1'b0;
      r[k] = same;
    end
    return r;
  endfunction

  task automatic check(input logic [7:0] exp, input string req);
    nChecks++;
    if (laneEq !== exp) begin
      nFails++;
      $display("FAIL %s gates=%h a=%h b=%h actual=%h expected=%h",
               req, gates, opA, opB, laneEq, exp);
    end
  endtask

  task automatic apply(input logic [6:0] g, input logic [63:0] a, input logic [63:0] b);
    @(posedge clk);
    gates = g; opA = a; opB = b;
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      nFails++;
      nChecks++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    gates = '0; opA = '0; opB = '0;
    #1;
    check(8'hFF, "R8 idle inputs");

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      apply(VECS[v].g, VECS[v].a, VECS[v].b);
      check(VECS[v].exp, "R1 R2 R3 table");
    end

    // R7: same-cycle response without any clock edge
    @(negedge clk);
    gates = 7'h00; opA = 64'h5; opB = 64'h5;
    #0.5;
    check(8'hFF, "R7 settle equal");
    opB = 64'h4;
    #0.5;
    check(8'h00, "R7 settle unequal");

    // Sweep all boundary patterns
    for (int g = 0; g < 128; g++) begin
      logic [63:0] a, b;
      a = {$urandom, $urandom};
      apply(g[6:0], a, a);
      check(8'hFF, "R8 sweep equal");
      for (int t = 0; t < 4; t++) begin
        int lane;
        lane = $urandom_range(7, 0);
        b = a;
        b[lane*8 +: 8] = b[lane*8 +: 8] ^ 8'(1 + $urandom_range(254, 0));
        apply(g[6:0], a, b);
        check(refEq(g[6:0], a, b), "R2 R6 sweep one-byte diff");
      end
      b = {$urandom, $urandom};
      apply(g[6:0], a, b);
      check(refEq(g[6:0], a, b), "R2 R3 sweep random");
    end

    // Directed: each lane alone under full split (R5) and no split (R4)
    for (int k = 0; k < 8; k++) begin
      logic [63:0] b;
      b = '0;
      b[k*8] = 1'b1;
      apply(7'h7F, 64'h0, b);
      check(~(8'h01 << k), "R5 single-byte split");
      apply(7'h00, 64'h0, b);
      check(8'h00, "R4 whole-word");
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule